// File: doc/BRIEF.md
# Parallel Port FIFO DMA Requester

This block decides when a parallel-port FIFO asks the host for service. It watches the FIFO fill level, the transfer direction and two host control bits: a DMA enable and a service flag. From these it drives an active-high DMA request or, when DMA is off, an interrupt. The host DMA engine answers with an active-low acknowledge and a read strobe, both asynchronous. The block brings these into its clock domain and finds their edges. A terminal-count input, qualified by the acknowledge, ends a transfer.

Terminal count sets the service flag, which turns DMA off and raises the interrupt. The request then stays off until software writes the flag back to zero. A burst limiter counts acknowledge cycles while the request is up. After `BURST_MAX` cycles it forces the request low. The request stays low until the acknowledge has been idle for a parameterised holdoff time, computed from the clock frequency. In programmed-I/O mode, a threshold compare on the fill level drives the interrupt. A threshold of 16 acts as 15.

Top module: `ppf_dma_req`

## Requirements
- R1: With `dma_en_i`=1 and the service flag 0, `drq_o` is asserted within two cycles when the FIFO has work. When `to_host_i`=1 (FIFO-to-host), work means `fifo_level_i` >= 1. When `to_host_i`=0, work means `fifo_level_i` < DEPTH (16).
- R2: In the FIFO-to-host direction, `drq_o` falls when the level reaches 0. It rises again once the level is 1 or more.
- R3: When the level is exactly 1, a new acknowledge activation drops `drq_o` three cycles after `dack_n_i` falls. If the acknowledge is already held active, the falling edge of `rd_n_i` does this instead.
- R4: If `tc_i`=1 while the synchronised acknowledge is active, the block drops `drq_o`, sets `svc_o` to 1 and raises `irq_o`, all on the next clock edge.
- R5: While `svc_o` is 1, `drq_o` stays 0 whatever the level. It returns after software writes 0 to the flag (`svc_wr_i`=1, `svc_wr_val_i`=0), provided there is still work.
- R6: A request that has seen `BURST_MAX` (32) acknowledge activations is withdrawn. It is not withdrawn after only 31.
- R7: After a burst-cap drop, `drq_o` stays 0 until the acknowledge has been inactive for `ceil(HOLD_NS*CLK_MHZ/1000)` consecutive cycles (70 by default). Any acknowledge activation during the wait restarts the count.
- R8: `fifo_sel_o` equals the inverse of `dack_n_i`, with no clock delay and no address term.
- R9: With `dma_en_i`=0 and the service flag 0, `drq_o` stays 0. `irq_o` is 1 in the cycle after either of these holds: in the FIFO-to-host direction, level >= threshold; in the other direction, free space (DEPTH - level) >= threshold.
- R10: A `thr_i` value above DEPTH-1 (that is, 16) acts as DEPTH-1 (15).
- R11: During reset, `drq_o`, `irq_o` and `svc_o` are 0.
- R12: Writing 0 to the service flag clears the interrupt that terminal count raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level_i | input | LVL_W | Bytes held in the FIFO (0..DEPTH) |
| thr_i | input | LVL_W | Programmed-I/O interrupt threshold |
| to_host_i | input | 1 | 1: FIFO-to-host, 0: host-to-FIFO |
| dma_en_i | input | 1 | DMA enable control bit |
| svc_wr_i | input | 1 | Software write strobe for the service flag |
| svc_wr_val_i | input | 1 | Value written to the service flag |
| dack_n_i | input | 1 | Asynchronous active-low DMA acknowledge |
| rd_n_i | input | 1 | Asynchronous active-low I/O read strobe |
| tc_i | input | 1 | Terminal count, valid while acknowledge active |
| drq_o | output | 1 | DMA request, active high |
| irq_o | output | 1 | Service interrupt |
| svc_o | output | 1 | Current service flag |
| fifo_sel_o | output | 1 | FIFO select driven by acknowledge |

## Verification
A burst counter that has drifted shows up as `drq_o` falling one beat early or late around the 32nd acknowledge. That error is visible three cycles after the acknowledge edge that should, or should not, end the burst. A holdoff timer that fails to restart, or that runs short, brings the request back too soon: within 70 cycles of the last idle acknowledge instead of after it. A service flag or terminal-count state left wrong shows as a request that returns without the software clear, or never returns, and as `irq_o` staying high after the clear. These faults appear one to two cycles after the write.

// File: rtl/ppf_dma_pkg.sv
package ppf_dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_HOLD = 2'd2
   } req_st_e;

   // clock cycles covering a time in ns, rounded up
   function automatic int hold_cycles(input int clk_mhz, input int time_ns);
      return (time_ns * clk_mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/ppf_strobe_sync.sv
module ppf_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   output logic act_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ppf_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;
   assign chain[0] = pin_n_i;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= 1'b1;
         else        chain[i+1] <= chain[i];
      end
   end

   assign act_o = ~chain[STAGES];
endmodule

// File: rtl/ppf_burst_gate.sv
module ppf_burst_gate #(
   parameter int BURST_MAX = 32,
   localparam int CW = (BURST_MAX > 1) ? $clog2(BURST_MAX) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic beat_i,
   output logic cap_o
);
   if (BURST_MAX < 1) begin : g_bad_burst
      $error("ppf_burst_gate: BURST_MAX must be at least 1");
   end

   localparam logic [CW-1:0] LAST = CW'(BURST_MAX - 1);

   logic [CW-1:0] cnt_q;

   assign cap_o = en_i & beat_i & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!en_i)        cnt_q <= '0;
      else if (beat_i && !cap_o) cnt_q <= cnt_q + 1'b1;
   end

   AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      en_i && beat_i && !cap_o |=> cnt_q != '0 || !$past(en_i));  // R6
endmodule

// File: rtl/ppf_ack_idle_timer.sv
module ppf_ack_idle_timer #(
   parameter int HOLD_CYC = 70,
   localparam int TW = $clog2(HOLD_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic busy_i,
   output logic done_o
);
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("ppf_ack_idle_timer: HOLD_CYC must be at least 1");
   end

   localparam logic [TW-1:0] TOP = TW'(HOLD_CYC);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!en_i)        cnt_q <= '0;
      else if (busy_i)       cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = en_i & ~busy_i & (cnt_q == TOP);

   AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(!busy_i));  // R7
endmodule

// File: rtl/ppf_dma_req.sv
module ppf_dma_req
   import ppf_dma_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int BURST_MAX   = 32,
   parameter int CLK_MHZ     = 200,
   parameter int HOLD_NS     = 350,
   parameter int SYNC_STAGES = 2,
   localparam int LVL_W      = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fifo_level_i,
   input  logic [LVL_W-1:0] thr_i,
   input  logic             to_host_i,
   input  logic             dma_en_i,
   input  logic             svc_wr_i,
   input  logic             svc_wr_val_i,
   input  logic             dack_n_i,
   input  logic             rd_n_i,
   input  logic             tc_i,
   output logic             drq_o,
   output logic             irq_o,
   output logic             svc_o,
   output logic             fifo_sel_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("ppf_dma_req: DEPTH must be at least 2");
   end
   if (CLK_MHZ < 1 || HOLD_NS < 1) begin : g_bad_time
      $error("ppf_dma_req: CLK_MHZ and HOLD_NS must be positive");
   end

   localparam int              HOLD_CYC = hold_cycles(CLK_MHZ, HOLD_NS);
   localparam logic [LVL_W-1:0] FULL    = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] THR_CAP = LVL_W'(DEPTH - 1);
   localparam logic [LVL_W-1:0] ONE     = LVL_W'(1);

   // ---------------- strobe synchronisers and edges ----------------
   logic ack_act, ack_act_d, rd_act, rd_act_d;
   logic ack_fall, rd_fall;

   ppf_strobe_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .pin_n_i(dack_n_i), .act_o(ack_act));

   ppf_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .pin_n_i(rd_n_i), .act_o(rd_act));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_act_d <= 1'b0;
         rd_act_d  <= 1'b0;
      end else begin
         ack_act_d <= ack_act;
         rd_act_d  <= rd_act;
      end
   end

   assign ack_fall = ack_act & ~ack_act_d;
   assign rd_fall  = rd_act & ~rd_act_d;

   assign fifo_sel_o = ~dack_n_i;

   // ---------------- service flag and terminal count ----------------
   logic svc_q, tc_pend_q, pio_q;
   logic tc_evt, dma_ok, pio_mode, pio_hit, want, last_drop;
   logic [LVL_W-1:0] eff_thr, free_sp;

   assign tc_evt = tc_i & ack_act;
   assign dma_ok = dma_en_i & ~svc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_q     <= 1'b0;
         tc_pend_q <= 1'b0;
      end else if (tc_evt) begin
         svc_q     <= 1'b1;
         tc_pend_q <= 1'b1;
      end else if (svc_wr_i) begin
         svc_q <= svc_wr_val_i;
         if (!svc_wr_val_i) tc_pend_q <= 1'b0;
      end
   end

   // ---------------- programmed-I/O threshold interrupt ----------------
   assign eff_thr  = (thr_i > THR_CAP) ? THR_CAP : thr_i;
   assign free_sp  = FULL - fifo_level_i;
   assign pio_mode = ~dma_en_i & ~svc_q;
   assign pio_hit  = to_host_i ? (fifo_level_i >= eff_thr) : (free_sp >= eff_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pio_q <= 1'b0;
      else        pio_q <= pio_mode & pio_hit;
   end

   assign irq_o = tc_pend_q | pio_q;
   assign svc_o = svc_q;

   // ---------------- request state machine ----------------
   req_st_e st_q, st_d;
   logic    cap_hit, hold_done, in_req, in_hold;

   assign want      = to_host_i ? (fifo_level_i != '0) : (fifo_level_i != FULL);
   assign last_drop = to_host_i & (fifo_level_i == ONE) &
                      (ack_fall | (rd_fall & ack_act));
   assign in_req    = (st_q == ST_REQ);
   assign in_hold   = (st_q == ST_HOLD);

   ppf_burst_gate #(.BURST_MAX(BURST_MAX)) u_burst (
      .clk(clk), .rst_n(rst_n), .en_i(in_req), .beat_i(ack_fall), .cap_o(cap_hit));

   ppf_ack_idle_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .en_i(in_hold), .busy_i(ack_act), .done_o(hold_done));

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (dma_ok && want && !tc_evt) st_d = ST_REQ;
         ST_REQ: begin
            if (tc_evt || !dma_ok)  st_d = ST_IDLE;
            else if (cap_hit)       st_d = ST_HOLD;
            else if (last_drop)     st_d = ST_IDLE;
            else if (!want)         st_d = ST_IDLE;
         end
         ST_HOLD: if (tc_evt || hold_done) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign drq_o = in_req;

   // ---------------- assertions ----------------
   AST_RISE_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drq_o) |-> $past(want && dma_ok));  // R1
   AST_TC_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      tc_evt |=> svc_o && irq_o && !drq_o);  // R4
   AST_SVC_BLOCKS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
      svc_q && $past(svc_q) |-> !drq_o);  // R5
   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      in_hold && !hold_done |=> !drq_o);  // R7
   AST_PIO_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!dma_en_i) |-> !drq_o);  // R9
   AST_ACK_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fall |=> !ack_fall);  // R3
   AST_SEL_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_sel_o == !dack_n_i);  // R8
endmodule

// File: tb/ppf_dma_req_tb_top.sv
module ppf_dma_req_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] lvl = '0, thr = '0;
   logic       to_host = 1'b1, dma_en = 1'b0, svc_wr = 1'b0, svc_val = 1'b0;
   logic       dack_n = 1'b1, rd_n = 1'b1, tc = 1'b0;
   logic       drq, irq, svc, sel;
   int         checks = 0, errors = 0;

   always #2.5 clk = ~clk;  // 200 MHz

   ppf_dma_req dut_i (
      .clk(clk), .rst_n(rst_n), .fifo_level_i(lvl), .thr_i(thr),
      .to_host_i(to_host), .dma_en_i(dma_en), .svc_wr_i(svc_wr),
      .svc_wr_val_i(svc_val), .dack_n_i(dack_n), .rd_n_i(rd_n), .tc_i(tc),
      .drq_o(drq), .irq_o(irq), .svc_o(svc), .fifo_sel_o(sel));

   typedef struct packed {
      logic       dir;
      logic       en;
      logic [4:0] lv;
      logic [4:0] th;
      logic       e_drq;
      logic       e_irq;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b1, 5'd0,  5'd0,  1'b0, 1'b0},  // R1 empty, to host
      '{1'b1, 1'b1, 5'd3,  5'd0,  1'b1, 1'b0},  // R1
      '{1'b1, 1'b1, 5'd16, 5'd0,  1'b1, 1'b0},  // R1 full
      '{1'b0, 1'b1, 5'd16, 5'd0,  1'b0, 1'b0},  // R1 full, from host
      '{1'b0, 1'b1, 5'd5,  5'd0,  1'b1, 1'b0},  // R1
      '{1'b1, 1'b0, 5'd4,  5'd8,  1'b0, 1'b0},  // R9 below threshold
      '{1'b1, 1'b0, 5'd8,  5'd8,  1'b0, 1'b1},  // R9 at threshold
      '{1'b1, 1'b0, 5'd15, 5'd16, 1'b0, 1'b1},  // R10 16 acts as 15
      '{1'b1, 1'b0, 5'd14, 5'd16, 1'b0, 1'b0},  // R10
      '{1'b1, 1'b0, 5'd15, 5'd15, 1'b0, 1'b1},  // R10 reference
      '{1'b0, 1'b0, 5'd10, 5'd6,  1'b0, 1'b1},  // R9 free 6
      '{1'b0, 1'b0, 5'd11, 5'd6,  1'b0, 1'b0},  // R9 free 5
      '{1'b0, 1'b0, 5'd1,  5'd16, 1'b0, 1'b1}   // R10 free 15
   };

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one acknowledge pulse: low for 3 cycles, high for 3
   task automatic ack_pulse();
      dack_n = 1'b0; cyc(3);
      dack_n = 1'b1; cyc(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R11 reset state
      lvl = 5'd8; dma_en = 1'b1; to_host = 1'b1;
      cyc(4);
      chk(drq, 1'b0, "R11 drq in reset");
      chk(irq, 1'b0, "R11 irq in reset");
      chk(svc, 1'b0, "R11 svc in reset");
      rst_n = 1'b1;
      cyc(3);

      // vector table (R1 R9 R10)
      for (int i = 0; i < NV; i++) begin
         to_host = VECS[i].dir; dma_en = VECS[i].en;
         lvl = VECS[i].lv; thr = VECS[i].th;
         cyc(3);
         chk(drq, VECS[i].e_drq, $sformatf("R1/R9/R10 vector %0d drq", i));
         chk(irq, VECS[i].e_irq, $sformatf("R1/R9/R10 vector %0d irq", i));
      end

      // R2 empty and refill
      to_host = 1'b1; dma_en = 1'b1; thr = 5'd0; lvl = 5'd8; cyc(3);
      chk(drq, 1'b1, "R2 request with data");
      lvl = 5'd0; cyc(2);
      chk(drq, 1'b0, "R2 drop on empty");
      lvl = 5'd1; cyc(2);
      chk(drq, 1'b1, "R2 reassert on one byte");

      // R3 last byte via acknowledge edge; R8 select
      dack_n = 1'b0; #1;
      chk(sel, 1'b1, "R8 select with ack active");
      cyc(3);
      chk(drq, 1'b0, "R3 drop on ack for last byte");
      lvl = 5'd0; cyc(1);
      dack_n = 1'b1; #1;
      chk(sel, 1'b0, "R8 select with ack idle");
      cyc(4);

      // R3 last byte via read strobe while ack held
      lvl = 5'd8; cyc(3);
      dack_n = 1'b0; cyc(4);
      lvl = 5'd1; cyc(2);
      chk(drq, 1'b1, "R3 held ack alone does not drop");
      rd_n = 1'b0; cyc(3);
      chk(drq, 1'b0, "R3 drop on read strobe");
      lvl = 5'd0; cyc(1);
      rd_n = 1'b1; dack_n = 1'b1; cyc(4);

      // R4 R5 R12 terminal count
      lvl = 5'd8; cyc(3);
      dack_n = 1'b0; cyc(4);
      tc = 1'b1; cyc(1);
      tc = 1'b0;
      chk(drq, 1'b0, "R4 drop on terminal count");
      chk(svc, 1'b1, "R4 service flag set");
      chk(irq, 1'b1, "R4 interrupt raised");
      dack_n = 1'b1; cyc(6);
      chk(drq, 1'b0, "R5 stays off while flag set");
      svc_wr = 1'b1; svc_val = 1'b0; cyc(1);
      svc_wr = 1'b0; cyc(1);
      chk(drq, 1'b1, "R5 reassert after flag clear");
      chk(irq, 1'b0, "R12 interrupt cleared");
      chk(svc, 1'b0, "R12 flag cleared");

      // R6 burst cap, R7 holdoff
      cyc(2);
      for (int k = 0; k < 31; k++) ack_pulse();
      chk(drq, 1'b1, "R6 still up after 31 cycles");
      dack_n = 1'b0; cyc(3);
      chk(drq, 1'b0, "R6 drop at 32nd cycle");
      cyc(1);
      dack_n = 1'b1; cyc(40);
      chk(drq, 1'b0, "R7 low early in holdoff");
      dack_n = 1'b0; cyc(3);
      dack_n = 1'b1; cyc(60);
      chk(drq, 1'b0, "R7 ack restarts holdoff");
      cyc(30);
      chk(drq, 1'b1, "R7 reassert after idle gap");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule